// File: doc/BRIEF.md
# Integer Execute Unit with Lane Mask Fill

This block is the integer execute stage of a 64-bit core. Each cycle it can take one operation: an 8-bit opcode, the current value of the destination register, a second operand that is either a register value or an immediate, the destination register index and a shift amount. One clock later it presents a registered result, a write strobe for the register file, the destination index, and an optional update of the carry/borrow flag.

It covers addition and subtraction with carry or borrow, increment and decrement, the bitwise operations, logical shifts, immediate move, a low-half multiply and an unsigned divide. It also has four lane fill operations. Each one replaces only the lowest byte, 2-byte, 4-byte or 8-byte lane of the destination with the low bits of the second operand, and keeps the rest of the destination as it was. Register index 0 is a hardwired zero register, so a result aimed at it is never written.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `out_valid`, `wr_en` and `flag_we` are low.
- R2: ADD (0x01) gives `dst_val + src_val` and sets `carry` to the carry out of bit 63. SUB (0x02) gives `dst_val - src_val` and sets `carry` to 1 exactly when `dst_val < src_val` (unsigned). Both raise `flag_we`.
- R3: INC (0x05) gives `dst_val + 1` with carry set when `dst_val` is all ones. DEC (0x06) gives `dst_val - 1` with borrow set when `dst_val` is zero. Both raise `flag_we`.
- R4: OR (0x07), XOR (0x08) and AND (0x09) combine `dst_val` with `src_val`. NOT (0x0A) gives `~dst_val`. None of them raises `flag_we`.
- R5: SLL (0x0B) and SRL (0x0C) are logical shifts of `dst_val` by `shamt[5:0]`. The upper bits of `shamt` are ignored.
- R6: MOV_IMM (0x0D) gives `src_val` unchanged.
- R7: MUL (0x03) gives the low 64 bits of the unsigned product `dst_val * src_val`.
- R8: DIV (0x04) gives the unsigned quotient `dst_val / src_val`. When `src_val` is zero the result is all ones. DIV never raises `flag_we`.
- R9: Lane fill opcodes 0x10, 0x11, 0x12 and 0x13 replace the low 8, 16, 32 or 64 bits of `dst_val` with the same low bits of `src_val`, and keep all higher bits of `dst_val`.
- R10: When `dst_idx` is 0, `wr_en` stays low. The carry update of R2/R3 still takes place.
- R11: NOP (0x00), HLT (0x0E), BR (0x0F) and every unlisted opcode leave `wr_en` and `flag_we` low.
- R12: Outputs are registered with one cycle of latency. `out_valid` is the previous cycle's `in_valid`, `wr_idx` is the previous `dst_idx`, and without `in_valid` there is no write and no flag update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 8 | Operation code |
| dst_idx | input | 4 | Destination register index (0 is the zero register) |
| dst_val | input | 64 | Current value of the destination register |
| src_val | input | 64 | Second operand, register or immediate |
| shamt | input | 8 | Shift amount; only the low 6 bits are used |
| out_valid | output | 1 | Registered result is valid |
| res | output | 64 | Registered result |
| wr_en | output | 1 | Write the result to `wr_idx` |
| wr_idx | output | 4 | Destination index for the write |
| flag_we | output | 1 | Update the carry flag |
| carry | output | 1 | New carry/borrow value |

## Verification
All state sits in one output register stage, so any decode error appears at the ports exactly one cycle after the operation is presented. It shows up as a wrong `res`, a write strobe that is missing or extra (most importantly a write to index 0), or a flag update on an operation that should not touch the flag. Random operations with random operands are mixed with directed edge values: carry out of all ones, borrow from zero, divide by zero, shift amounts with high bits set, and every lane size. Each of these exposes a wrong lane boundary, a wrong carry polarity or a missed zero-register guard on the next cycle.

// File: rtl/ieu_pkg.sv
package ieu_pkg;
  localparam logic [7:0] OP_NOP  = 8'h00;
  localparam logic [7:0] OP_ADD  = 8'h01;
  localparam logic [7:0] OP_SUB  = 8'h02;
  localparam logic [7:0] OP_MUL  = 8'h03;
  localparam logic [7:0] OP_DIV  = 8'h04;
  localparam logic [7:0] OP_INC  = 8'h05;
  localparam logic [7:0] OP_DEC  = 8'h06;
  localparam logic [7:0] OP_OR   = 8'h07;
  localparam logic [7:0] OP_XOR  = 8'h08;
  localparam logic [7:0] OP_AND  = 8'h09;
  localparam logic [7:0] OP_NOT  = 8'h0A;
  localparam logic [7:0] OP_SLL  = 8'h0B;
  localparam logic [7:0] OP_SRL  = 8'h0C;
  localparam logic [7:0] OP_MOVI = 8'h0D;
  localparam logic [7:0] OP_HLT  = 8'h0E;
  localparam logic [7:0] OP_BR   = 8'h0F;
  localparam logic [7:0] OP_FILL = 8'h10;

  typedef enum logic [1:0] {AS_ADD, AS_SUB, AS_INC, AS_DEC} addsub_e;
  typedef enum logic [2:0] {LG_AND, LG_OR, LG_XOR, LG_NOT, LG_SLL, LG_SRL} logic_e;

  typedef struct packed {
    logic wr;
    logic fwe;
  } ctl_t;
endpackage

// File: rtl/ieu_addsub.sv
module ieu_addsub
  import ieu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  addsub_e         sel,
  output logic [XLEN-1:0] sum,
  output logic            cy
);
  logic            is_sub;
  logic [XLEN-1:0] bsel;
  logic [XLEN-1:0] binv;
  logic [XLEN:0]   ext;

  always_comb begin
    is_sub = (sel == AS_SUB) || (sel == AS_DEC);
    bsel   = ((sel == AS_INC) || (sel == AS_DEC)) ? {{(XLEN-1){1'b0}}, 1'b1} : b;
    binv   = is_sub ? ~bsel : bsel;
    ext    = {1'b0, a} + {1'b0, binv} + {{XLEN{1'b0}}, is_sub};
    sum    = ext[XLEN-1:0];
    // a + ~b + 1 carries out exactly when no borrow occurs
    cy     = is_sub ? ~ext[XLEN] : ext[XLEN];
  end
endmodule

// File: rtl/ieu_logic.sv
module ieu_logic
  import ieu_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SH_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [SH_W-1:0] sh,
  input  logic_e          sel,
  output logic [XLEN-1:0] y
);
  always_comb begin
    unique case (sel)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      LG_NOT:  y = ~a;
      LG_SLL:  y = a << sh;
      LG_SRL:  y = a >> sh;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/ieu_muldiv.sv
module ieu_muldiv #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] prod_lo,
  output logic [XLEN-1:0] quot
);
  logic [XLEN-1:0] prod;
  always_comb begin
    prod    = a * b;
    prod_lo = prod;
    quot    = (b == '0) ? '1 : (a / b);
  end
endmodule

// File: rtl/ieu_lanefill.sv
module ieu_lanefill #(
  parameter int XLEN = 64,
  localparam int NLANE = $clog2(XLEN / 8) + 1,
  localparam int LSEL_W = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic [XLEN-1:0]   dst,
  input  logic [XLEN-1:0]   mask,
  input  logic [LSEL_W-1:0] sel,
  output logic [XLEN-1:0]   y
);
  logic [XLEN-1:0] cand [NLANE];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = 8 << g;
    if (LW >= XLEN) begin : g_full
      assign cand[g] = mask;
    end else begin : g_part
      assign cand[g] = {dst[XLEN-1:LW], mask[LW-1:0]};
    end
  end

  assign y = cand[sel];
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import ieu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int REG_W  = 4,
  parameter int SHIN_W = 8,
  localparam int SH_W   = $clog2(XLEN),
  localparam int NLANE  = $clog2(XLEN / 8) + 1,
  localparam int LSEL_W = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        op,
  input  logic [REG_W-1:0]  dst_idx,
  input  logic [XLEN-1:0]   dst_val,
  input  logic [XLEN-1:0]   src_val,
  input  logic [SHIN_W-1:0] shamt,
  output logic              out_valid,
  output logic [XLEN-1:0]   res,
  output logic              wr_en,
  output logic [REG_W-1:0]  wr_idx,
  output logic              flag_we,
  output logic              carry
);
  addsub_e         as_sel;
  logic_e          lg_sel;
  logic [XLEN-1:0] as_sum, lg_y, mul_y, div_y, fill_y;
  logic            as_cy;
  logic [XLEN-1:0] nxt_res;
  ctl_t            nxt_ctl;
  logic            unused_sh_hi;

  assign unused_sh_hi = ^shamt[SHIN_W-1:SH_W];

  always_comb begin
    unique case (op)
      OP_SUB:  as_sel = AS_SUB;
      OP_INC:  as_sel = AS_INC;
      OP_DEC:  as_sel = AS_DEC;
      default: as_sel = AS_ADD;
    endcase
    unique case (op)
      OP_OR:   lg_sel = LG_OR;
      OP_XOR:  lg_sel = LG_XOR;
      OP_NOT:  lg_sel = LG_NOT;
      OP_SLL:  lg_sel = LG_SLL;
      OP_SRL:  lg_sel = LG_SRL;
      default: lg_sel = LG_AND;
    endcase
  end

  ieu_addsub #(.XLEN(XLEN)) u_as (
    .a(dst_val), .b(src_val), .sel(as_sel), .sum(as_sum), .cy(as_cy)
  );

  ieu_logic #(.XLEN(XLEN)) u_lg (
    .a(dst_val), .b(src_val), .sh(shamt[SH_W-1:0]), .sel(lg_sel), .y(lg_y)
  );

  ieu_muldiv #(.XLEN(XLEN)) u_md (
    .a(dst_val), .b(src_val), .prod_lo(mul_y), .quot(div_y)
  );

  ieu_lanefill #(.XLEN(XLEN)) u_lf (
    .dst(dst_val), .mask(src_val), .sel(op[LSEL_W-1:0]), .y(fill_y)
  );

  // decode: select the result and the write/flag strobes
  always_comb begin
    nxt_res = '0;
    nxt_ctl = '{wr: 1'b0, fwe: 1'b0};
    unique case (op)
      OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
        nxt_res = as_sum;
        nxt_ctl = '{wr: 1'b1, fwe: 1'b1};
      end
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_SLL, OP_SRL: begin
        nxt_res = lg_y;
        nxt_ctl.wr = 1'b1;
      end
      OP_MUL: begin
        nxt_res = mul_y;
        nxt_ctl.wr = 1'b1;
      end
      OP_DIV: begin
        nxt_res = div_y;
        nxt_ctl.wr = 1'b1;
      end
      OP_MOVI: begin
        nxt_res = src_val;
        nxt_ctl.wr = 1'b1;
      end
      default: begin
        if (op >= OP_FILL && op < OP_FILL + 8'(NLANE)) begin
          nxt_res = fill_y;
          nxt_ctl.wr = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res       <= '0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      flag_we   <= 1'b0;
      carry     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      res       <= nxt_res;
      wr_idx    <= dst_idx;
      wr_en     <= in_valid && nxt_ctl.wr && (dst_idx != '0);
      flag_we   <= in_valid && nxt_ctl.fwe;
      carry     <= nxt_ctl.fwe ? as_cy : 1'b0;
    end
  end

  // ---------------- assertions ----------------
  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !wr_en && !flag_we));

  assert_no_zero_write_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dst_idx == '0) |=> !wr_en);

  assert_flag_only_arith_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(op == OP_ADD || op == OP_SUB || op == OP_INC || op == OP_DEC))
      |=> !flag_we);

  assert_lane_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_FILL) |=> (res[XLEN-1:8] == $past(dst_val[XLEN-1:8])));

  assert_div_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_DIV && src_val == '0) |=> (res == '1 && !flag_we));

  assert_idle_ops_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == OP_NOP || op == OP_HLT || op == OP_BR)) |=> (!wr_en && !flag_we));
endmodule

// File: tb/sim_int_exec_unit.sv
`timescale 1ns/1ps
module sim_int_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  op = 8'h00;
  logic [3:0]  dst_idx = 4'd0;
  logic [63:0] dst_val = 64'd0;
  logic [63:0] src_val = 64'd0;
  logic [7:0]  shamt = 8'd0;
  logic        out_valid, wr_en, flag_we, carry;
  logic [63:0] res;
  logic [3:0]  wr_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  int_exec_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .dst_idx(dst_idx),
    .dst_val(dst_val), .src_val(src_val), .shamt(shamt), .out_valid(out_valid),
    .res(res), .wr_en(wr_en), .wr_idx(wr_idx), .flag_we(flag_we), .carry(carry)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] o);
    case (o)
      8'h01, 8'h02: return "R2";
      8'h05, 8'h06: return "R3";
      8'h07, 8'h08, 8'h09, 8'h0A: return "R4";
      8'h0B, 8'h0C: return "R5";
      8'h0D: return "R6";
      8'h03: return "R7";
      8'h04: return "R8";
      8'h10, 8'h11, 8'h12, 8'h13: return "R9";
      default: return "R11";
    endcase
  endfunction

  // expected result: {writes, flag update, carry} and value
  task automatic model(input logic [7:0] o, input logic [63:0] a, input logic [63:0] b,
                       input logic [7:0] s, output bit w, output bit f, output bit c,
                       output logic [63:0] r);
    logic [64:0] t;
    w = 1; f = 0; c = 0; r = 64'd0;
    case (o)
      8'h01: begin t = {1'b0, a} + {1'b0, b}; r = t[63:0]; c = t[64]; f = 1; end
      8'h02: begin r = a - b; c = (a < b); f = 1; end
      8'h05: begin r = a + 64'd1; c = (a == '1); f = 1; end
      8'h06: begin r = a - 64'd1; c = (a == 64'd0); f = 1; end
      8'h07: r = a | b;
      8'h08: r = a ^ b;
      8'h09: r = a & b;
      8'h0A: r = ~a;
      8'h0B: r = a << s[5:0];
      8'h0C: r = a >> s[5:0];
      8'h0D: r = b;
      8'h03: r = a * b;
      8'h04: r = (b == 0) ? '1 : a / b;
      8'h10: r = {a[63:8], b[7:0]};
      8'h11: r = {a[63:16], b[15:0]};
      8'h12: r = {a[63:32], b[31:0]};
      8'h13: r = b;
      default: w = 0;
    endcase
  endtask

  task automatic run_op(input logic [7:0] o, input logic [3:0] idx, input logic [63:0] a,
                        input logic [63:0] b, input logic [7:0] s);
    bit w, f, c;
    logic [63:0] r;
    string t;
    model(o, a, b, s, w, f, c, r);
    t = tag_of(o);
    @(negedge clk);
    in_valid = 1; op = o; dst_idx = idx; dst_val = a; src_val = b; shamt = s;
    @(negedge clk);
    in_valid = 0;
    chk("R12", "out_valid", {63'd0, out_valid}, 64'd1);
    chk("R12", "wr_idx", {60'd0, wr_idx}, {60'd0, idx});
    if (idx == 4'd0) chk("R10", "wr_en x0", {63'd0, wr_en}, 64'd0);
    else chk(t, "wr_en", {63'd0, wr_en}, {63'd0, w});
    chk(t, "flag_we", {63'd0, flag_we}, {63'd0, f});
    if (w) chk(t, "res", res, r);
    if (f) chk(t, "carry", {63'd0, carry}, {63'd0, c});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", {63'd0, out_valid}, 64'd0);
    chk("R1", "wr_en in reset", {63'd0, wr_en}, 64'd0);
    rst = 0;
    @(negedge clk);
    chk("R1", "flag_we after reset", {63'd0, flag_we}, 64'd0);

    // directed corners
    run_op(8'h01, 4'd1, '1, 64'd1, 8'd0);                     // R2 carry out
    run_op(8'h01, 4'd2, 64'd5, 64'd7, 8'd0);                  // R2 no carry
    run_op(8'h02, 4'd3, 64'd0, 64'd1, 8'd0);                  // R2 borrow
    run_op(8'h02, 4'd3, 64'd9, 64'd9, 8'd0);                  // R2 equal, no borrow
    run_op(8'h05, 4'd4, '1, 64'd0, 8'd0);                     // R3 inc wraps
    run_op(8'h06, 4'd4, 64'd0, 64'd0, 8'd0);                  // R3 dec borrows
    run_op(8'h0A, 4'd5, 64'h00FF_00FF_0000_1234, 64'd0, 8'd0);// R4 not
    run_op(8'h0B, 4'd6, 64'h1, 64'd0, 8'hC3);                 // R5 high shamt bits ignored
    run_op(8'h0C, 4'd6, 64'h8000_0000_0000_0000, 64'd0, 8'h7F);// R5
    run_op(8'h0D, 4'd7, 64'h1111, 64'hDEAD_BEEF_0000_0001, 8'd0); // R6
    run_op(8'h03, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 8'd0);// R7 low half
    run_op(8'h04, 4'd9, 64'd100, 64'd0, 8'd0);                // R8 divide by zero
    run_op(8'h04, 4'd9, 64'd100, 64'd7, 8'd0);                // R8
    for (int k = 0; k < 4; k++)                               // R9 every lane
      run_op(8'h10 + 8'(k), 4'd10, 64'hAAAA_AAAA_AAAA_AAAA, 64'h0123_4567_89AB_CDEF, 8'd0);
    run_op(8'h01, 4'd0, '1, 64'd1, 8'd0);                     // R10 x0, flag still updates
    run_op(8'h0D, 4'd0, 64'd0, 64'd5, 8'd0);                  // R10
    run_op(8'h00, 4'd1, 64'd1, 64'd1, 8'd0);                  // R11
    run_op(8'h0E, 4'd1, 64'd1, 64'd1, 8'd0);                  // R11
    run_op(8'h0F, 4'd1, 64'd1, 64'd1, 8'd0);                  // R11
    run_op(8'hFF, 4'd1, 64'd1, 64'd1, 8'd0);                  // R11 unknown

    // idle cycle: R12
    @(negedge clk);
    chk("R12", "idle out_valid", {63'd0, out_valid}, 64'd0);
    chk("R12", "idle wr_en", {63'd0, wr_en}, 64'd0);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [7:0]  o;
      logic [63:0] a, b;
      o = 8'($urandom % 22);
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (($urandom % 4) == 0) b = 64'($urandom % 8);
      run_op(o, 4'($urandom % 16), a, b, 8'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule